// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Radio Front-End

This block is the control port of a radio receiver front-end. A host reaches it over a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line back. Each transfer carries one address byte followed by one data byte, most significant bit first. The top bit of the address byte picks the direction: 1 writes, 0 reads. The low seven bits pick the register. The registers drive the front-end directly. They set the PLL feedback and reference division ratios, choose the reference clock source, enable the output clock buffers and the analog sub-circuits, set the output slew mode, and trim the charge pump and loop filter.

The block has two sets of reset values. A strap input chooses between them: one set suits a 16.368 MHz reference and the other a 19.2 MHz reference. A synchronous active-low load pulse from the chip's reset sequencer copies the chosen set into every register. The three divider registers go through a staging step. Writes to them land in a staging copy, and the 24-bit divider word that feeds the synthesizer changes only when the reference divider register is written. At that point the whole word changes at once.

Top module: `spi_cfg_bank`

## Requirements
- R1: A frame holds 16 bits, taken from `sdi` on rising `sclk` edges while `cs_n` is low, in this order: address bits 7..0, then data bits 7..0. Address bit 7 = 1 means write and bit 7 = 0 means read. Address bits [6:0] are the register index. A write takes effect on the 16th rising edge.
- R2: In a read frame, the block drives the addressed register's byte on `sdo`, D7 first. Each bit is launched on a falling edge, so the host can sample the bits on rising edges 9 to 16. `sdo` is 0 during the address phase and whenever `cs_n` is high.
- R3: Index 0x40 holds N[11:8] in bits [3:0], index 0x41 holds N[7:0], and index 0x42 holds R[5:0]. Bits outside these fields are stored and read as 0. A write to 0x40 or 0x41 changes only the staged copy, which reads back at once. `div_word` = {0x40 image, 0x41 image, 0x42 image} and the derived `n_ratio` and `r_ratio` change only on a write to 0x42. That write publishes the staged 0x40 and 0x41 together with the new 0x42 value.
- R4: Strap-dependent reset values. With strap 0: N = 96, R = 1, and index 0x43 = 0x0A. With strap 1: N = 1555, R = 19, and index 0x43 = 0x0F.
- R5: Reset values that do not depend on the strap: index 0x50 = 0x00, 0x51 = 0xBF, 0x52 = 0x1B, and 0x60 = 0x00.
- R6: Field outputs track the registers:
  - Index 0x43: bit 0 clock source is the VCO path, bit 1 slow slew, bit 2 crystal clock buffer, bit 3 receiver clock buffer.
  - Index 0x50: bit 1 IF buffer.
  - Index 0x51: bits 0 to 5 are VCO, PLL, RF amplifier, mixer, IF chain and AGC, and bit 7 is the receive master enable.
  - Index 0x52: charge-pump code in bits [1:0] and loop-filter code in bits [4:2]. Unused bits of 0x52 are stored and read as 0.
  - Index 0x60: bit 0 forces the receive chain on.
- R7: `cp_steps` gives the charge-pump current in 50 µA steps. It equals the code plus one, so codes 00, 01, 10 and 11 give 1, 2, 3 and 4.
- R8: If `cs_n` rises before the 16th bit, the frame changes no register and does not change `div_word`.
- R9: A write to an index outside the set {0x40, 0x41, 0x42, 0x43, 0x50, 0x51, 0x52, 0x60} changes nothing, and a read of such an index returns 0x00.
- R10: When `rst_n` is low at a rising `sclk` edge, every register and `div_word` load the set chosen by `strap_mode` at that edge. A change of `strap_mode` while `rst_n` is high has no effect.
- R11: A read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; also clocks all register state |
| rst_n | input | 1 | Synchronous active-low load of the reset values |
| strap_mode | input | 1 | Selects which reset value set is loaded |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| div_word | output | 24 | Published divider image {0x40, 0x41, 0x42} |
| n_ratio | output | 12 | Published feedback division ratio |
| r_ratio | output | 6 | Published reference division ratio |
| clk_src_vco | output | 1 | Receiver clock taken from the VCO divide path |
| slow_slew | output | 1 | Output drivers in slow slew mode |
| xclk_buf_en | output | 1 | Crystal clock output buffer on |
| rclk_buf_en | output | 1 | Receiver clock output buffer on |
| ifbuf_en | output | 1 | IF test buffer on |
| vco_en | output | 1 | VCO on |
| pll_en | output | 1 | PLL dividers and charge pump on |
| rfamp_en | output | 1 | RF amplifier on |
| mixer_en | output | 1 | Mixer on |
| ifchain_en | output | 1 | IF filter to ADC chain on |
| agc_en | output | 1 | Automatic gain control on |
| rx_master_en | output | 1 | Receive chain master enable |
| rx_force_on | output | 1 | Receive chain forced on regardless of pin |
| cp_code | output | 2 | Charge-pump current code |
| cp_steps | output | 3 | Charge-pump current in 50 µA steps |
| lf_code | output | 3 | Loop-filter setting |

## Verification
The bench builds the block with its default parameters: the two reset sets (N 96 and R 1, and N 1555 and R 19) and a 16-bit frame. With these values a reload from each strap value can be compared bit for bit against the fixed register images. The 16-bit frame lets a read and its returned byte fit inside one chip-select window. It also lets truncated frames of 5 and 12 bits exercise an abort in the address phase and an abort in the data phase.

// File: rtl/cfgbank_pkg.sv
// Package for the serial configuration register bank.
// Holds the frame geometry, the register index map, the per-register
// write masks and a function that builds a reset image from the
// divider ratios and the clock configuration nibble.
// Assumes one byte per register and a 7-bit register index.
package cfgbank_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int DSEL_W     = $clog2(DATA_W);
    localparam int NREG       = 8;
    localparam int IMG_W      = NREG * DATA_W;
    localparam int N_W        = 12;
    localparam int R_W        = 6;
    localparam int DIV_SLOTS  = 3;
    localparam int DIV_W      = DIV_SLOTS * DATA_W;

    // Slot positions inside the register image
    localparam int SLOT_NHI  = 0;
    localparam int SLOT_NLO  = 1;
    localparam int SLOT_RDIV = 2;
    localparam int SLOT_CLK  = 3;
    localparam int SLOT_TEST = 4;
    localparam int SLOT_ENBL = 5;
    localparam int SLOT_TRIM = 6;
    localparam int SLOT_RXCH = 7;

    // Strap-independent reset values
    localparam logic [DATA_W-1:0] DFLT_TEST = 8'h00;
    localparam logic [DATA_W-1:0] DFLT_ENBL = 8'hBF;
    localparam logic [DATA_W-1:0] DFLT_TRIM = 8'h1B;
    localparam logic [DATA_W-1:0] DFLT_RXCH = 8'h00;

    typedef struct packed {
        logic       clk_src_vco;
        logic       slow_slew;
        logic       xclk_buf_en;
        logic       rclk_buf_en;
        logic       ifbuf_en;
        logic       vco_en;
        logic       pll_en;
        logic       rfamp_en;
        logic       mixer_en;
        logic       ifchain_en;
        logic       agc_en;
        logic       rx_master_en;
        logic       rx_force_on;
        logic [1:0] cp_code;
        logic [2:0] lf_code;
    } cfg_fields_t;

    // Register index for each slot
    function automatic logic [IDX_W-1:0] slot_index(input int k);
        case (k)
            SLOT_NHI:  return 7'h40;
            SLOT_NLO:  return 7'h41;
            SLOT_RDIV: return 7'h42;
            SLOT_CLK:  return 7'h43;
            SLOT_TEST: return 7'h50;
            SLOT_ENBL: return 7'h51;
            SLOT_TRIM: return 7'h52;
            default:   return 7'h60;
        endcase
    endfunction

    // Implemented bits for each slot
    function automatic logic [DATA_W-1:0] slot_mask(input int k);
        case (k)
            SLOT_NHI:  return 8'h0F;
            SLOT_NLO:  return 8'hFF;
            SLOT_RDIV: return 8'h3F;
            SLOT_CLK:  return 8'h0F;
            SLOT_TEST: return 8'h02;
            SLOT_ENBL: return 8'hBF;
            SLOT_TRIM: return 8'h1F;
            default:   return 8'h01;
        endcase
    endfunction

    // Build a full reset image from ratios and clock nibble
    function automatic logic [IMG_W-1:0] build_image(input int n, input int r,
                                                     input logic [3:0] clk);
        logic [IMG_W-1:0] v;
        v = '0;
        v[SLOT_NHI*DATA_W  +: DATA_W] = DATA_W'((n >> 8) & 15);
        v[SLOT_NLO*DATA_W  +: DATA_W] = DATA_W'(n & 255);
        v[SLOT_RDIV*DATA_W +: DATA_W] = DATA_W'(r & 63);
        v[SLOT_CLK*DATA_W  +: DATA_W] = {4'b0000, clk};
        v[SLOT_TEST*DATA_W +: DATA_W] = DFLT_TEST;
        v[SLOT_ENBL*DATA_W +: DATA_W] = DFLT_ENBL;
        v[SLOT_TRIM*DATA_W +: DATA_W] = DFLT_TRIM;
        v[SLOT_RXCH*DATA_W +: DATA_W] = DFLT_RXCH;
        return v;
    endfunction

    // Divider word {nhi, nlo, rdiv} taken from an image
    function automatic logic [DIV_W-1:0] div_of_image(input logic [IMG_W-1:0] v);
        return {v[SLOT_NHI*DATA_W +: DATA_W], v[SLOT_NLO*DATA_W +: DATA_W],
                v[SLOT_RDIV*DATA_W +: DATA_W]};
    endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
// Serial frame engine.
// Counts bits, assembles the address and the full frame, announces the
// end of the address phase and the end of the frame, and streams read
// data back MSB first on falling clock edges.
// Assumes the bit counter is cleared asynchronously by cs_n high, so a
// frame cut short simply never reaches its last bit.
module spi_frame_shifter
    import cfgbank_pkg::*;
(
    input  logic                  sclk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sdi,
    input  logic [DATA_W-1:0]     rd_byte,
    output logic [ADDR_W-1:0]     addr_byte,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  sdo
);

    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-2:0] shreg;
    logic [DATA_W-1:0]     rd_q;
    logic                  rd_act;
    logic                  sdo_q;
    logic                  addr_done;
    logic [CNT_W-1:0]      bit_sel;

    // Bit position counter, cleared whenever the frame select is idle
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n)        bit_cnt <= '0;
        else if (!rst_n) bit_cnt <= '0;
        else             bit_cnt <= bit_cnt + 1'b1;
    end

    // Serial-in shift register holding the bits received so far
    always_ff @(posedge sclk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[FRAME_BITS-3:0], sdi};
    end

    assign addr_byte  = {shreg[ADDR_W-2:0], sdi};
    assign frame_word = {shreg, sdi};
    assign addr_done  = rst_n && (bit_cnt == CNT_W'(ADDR_W - 1));
    assign frame_done = rst_n && (bit_cnt == CNT_W'(FRAME_BITS - 1));

    // Capture read data and the direction once the address is complete
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            rd_act <= 1'b0;
        end else if (addr_done) begin
            rd_q   <= rd_byte;
            rd_act <= !addr_byte[ADDR_W-1];
        end
    end

    assign bit_sel = CNT_W'(FRAME_BITS - 1) - bit_cnt;

    // Launch one read bit per falling edge during the data phase
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n)
            sdo_q <= 1'b0;
        else if (!rst_n)
            sdo_q <= 1'b0;
        else if (rd_act && (bit_cnt >= CNT_W'(ADDR_W)))
            sdo_q <= rd_q[bit_sel[DSEL_W-1:0]];
        else
            sdo_q <= 1'b0;
    end

    assign sdo = sdo_q;

    AST_SDO_QUIET_ADDR: assert property (@(posedge sclk) disable iff (cs_n || !rst_n)
        (bit_cnt < CNT_W'(ADDR_W)) |-> (sdo == 1'b0)); // R2

    AST_FRAME_WRAP: assert property (@(posedge sclk) disable iff (cs_n || !rst_n)
        frame_done |=> (bit_cnt == '0)); // R1

endmodule

// File: rtl/cfg_regfile.sv
// Configuration register storage.
// Decodes completed write frames against the index map, masks data to
// the implemented bits, reloads the strap-selected reset image on a
// synchronous load pulse, serves the read mux and exposes the decoded
// field outputs and the divider staging values.
// Assumes writes arrive only as the single-cycle frame_done strobe.
module cfg_regfile
    import cfgbank_pkg::*;
#(
    parameter logic [IMG_W-1:0] IMG_A = '0,
    parameter logic [IMG_W-1:0] IMG_B = '0
) (
    input  logic                  sclk,
    input  logic                  rst_n,
    input  logic                  strap_mode,
    input  logic                  frame_done,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  commit,
    output logic [DIV_W-1:0]      stage_d,
    output logic [DIV_W-1:0]      stage_q,
    output cfg_fields_t           fields
);

    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic [DATA_W-1:0]     wdata;
    logic [NREG-1:0]       hit;
    logic [DATA_W-1:0]     q [NREG];
    logic [DATA_W-1:0]     d [NREG];
    logic [IMG_W-1:0]      bank_flat;

    assign wr_en  = frame_done && frame_word[FRAME_BITS-1];
    assign wr_idx = frame_word[FRAME_BITS-2:DATA_W];
    assign wdata  = frame_word[DATA_W-1:0];

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign hit[k] = wr_en && (wr_idx == slot_index(k));
        assign d[k]   = hit[k] ? (wdata & slot_mask(k)) : q[k];

        // One register slot: reset image load or masked write
        always_ff @(posedge sclk) begin
            if (!rst_n)
                q[k] <= strap_mode ? IMG_B[k*DATA_W +: DATA_W]
                                   : IMG_A[k*DATA_W +: DATA_W];
            else
                q[k] <= d[k];
        end

        assign bank_flat[k*DATA_W +: DATA_W] = q[k];
    end

    // Read mux: unmapped indices return zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (rd_idx == slot_index(k)) rd_data = q[k];
    end

    assign commit  = hit[SLOT_RDIV];
    assign stage_d = {d[SLOT_NHI], d[SLOT_NLO], d[SLOT_RDIV]};
    assign stage_q = {q[SLOT_NHI], q[SLOT_NLO], q[SLOT_RDIV]};

    // Field decode from the stored images
    always_comb begin
        fields.clk_src_vco  = q[SLOT_CLK][0];
        fields.slow_slew    = q[SLOT_CLK][1];
        fields.xclk_buf_en  = q[SLOT_CLK][2];
        fields.rclk_buf_en  = q[SLOT_CLK][3];
        fields.ifbuf_en     = q[SLOT_TEST][1];
        fields.vco_en       = q[SLOT_ENBL][0];
        fields.pll_en       = q[SLOT_ENBL][1];
        fields.rfamp_en     = q[SLOT_ENBL][2];
        fields.mixer_en     = q[SLOT_ENBL][3];
        fields.ifchain_en   = q[SLOT_ENBL][4];
        fields.agc_en       = q[SLOT_ENBL][5];
        fields.rx_master_en = q[SLOT_ENBL][7];
        fields.rx_force_on  = q[SLOT_RXCH][0];
        fields.cp_code      = q[SLOT_TRIM][1:0];
        fields.lf_code      = q[SLOT_TRIM][4:2];
    end

    AST_READ_NO_WRITE: assert property (@(posedge sclk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_flat)); // R11

    AST_UNMAPPED_IGNORED: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_en && (hit == '0)) |=> $stable(bank_flat)); // R9

endmodule

// File: rtl/div_publisher.sv
// Divider word publisher.
// Holds the 24-bit divider image seen by the synthesizer and replaces
// it in one step from the staging values when the reference divider
// register is written.
// Assumes commit is a single-cycle strobe aligned with the register write.
module div_publisher
    import cfgbank_pkg::*;
(
    input  logic             sclk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] dflt,
    input  logic             commit,
    input  logic [DIV_W-1:0] stage_d,
    input  logic [DIV_W-1:0] stage_q,
    output logic [DIV_W-1:0] pub
);

    // Published word: reset image or whole staged triple
    always_ff @(posedge sclk) begin
        if (!rst_n)      pub <= dflt;
        else if (commit) pub <= stage_d;
    end

    AST_PUB_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
        !commit |=> $stable(pub)); // R3

    AST_PUB_MATCH_STAGE: assert property (@(posedge sclk) disable iff (!rst_n)
        commit |=> (pub == stage_q)); // R3

endmodule

// File: rtl/spi_cfg_bank.sv
// Serial configuration register bank, top level.
// Connects the frame engine, the register storage and the divider
// publisher, and derives the ratio and charge-pump step outputs.
// Assumes all state lives in the serial clock domain and that rst_n is
// a synchronous load pulse from the reset sequencer.
module spi_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int         N_DFLT_A   = 96,
    parameter int         R_DFLT_A   = 1,
    parameter logic [3:0] CLK_DFLT_A = 4'b1010,
    parameter int         N_DFLT_B   = 1555,
    parameter int         R_DFLT_B   = 19,
    parameter logic [3:0] CLK_DFLT_B = 4'b1111
) (
    input  logic           sclk,
    input  logic           rst_n,
    input  logic           strap_mode,
    input  logic           cs_n,
    input  logic           sdi,
    output logic           sdo,
    output logic [23:0]    div_word,
    output logic [11:0]    n_ratio,
    output logic [5:0]     r_ratio,
    output logic           clk_src_vco,
    output logic           slow_slew,
    output logic           xclk_buf_en,
    output logic           rclk_buf_en,
    output logic           ifbuf_en,
    output logic           vco_en,
    output logic           pll_en,
    output logic           rfamp_en,
    output logic           mixer_en,
    output logic           ifchain_en,
    output logic           agc_en,
    output logic           rx_master_en,
    output logic           rx_force_on,
    output logic [1:0]     cp_code,
    output logic [2:0]     cp_steps,
    output logic [2:0]     lf_code
);

    localparam logic [IMG_W-1:0] IMG_A = build_image(N_DFLT_A, R_DFLT_A, CLK_DFLT_A);
    localparam logic [IMG_W-1:0] IMG_B = build_image(N_DFLT_B, R_DFLT_B, CLK_DFLT_B);
    localparam logic [DIV_W-1:0] DIV_A = div_of_image(IMG_A);
    localparam logic [DIV_W-1:0] DIV_B = div_of_image(IMG_B);

    logic [ADDR_W-1:0]     addr_byte;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_word;
    logic [DATA_W-1:0]     rd_data;
    logic                  commit;
    logic [DIV_W-1:0]      stage_d;
    logic [DIV_W-1:0]      stage_q;
    logic [DIV_W-1:0]      pub;
    cfg_fields_t           fields;

    spi_frame_shifter u_shifter (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .rd_byte    (rd_data),
        .addr_byte  (addr_byte),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .sdo        (sdo)
    );

    cfg_regfile #(
        .IMG_A (IMG_A),
        .IMG_B (IMG_B)
    ) u_regs (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .strap_mode (strap_mode),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .rd_idx     (addr_byte[IDX_W-1:0]),
        .rd_data    (rd_data),
        .commit     (commit),
        .stage_d    (stage_d),
        .stage_q    (stage_q),
        .fields     (fields)
    );

    div_publisher u_pub (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .dflt    (strap_mode ? DIV_B : DIV_A),
        .commit  (commit),
        .stage_d (stage_d),
        .stage_q (stage_q),
        .pub     (pub)
    );

    assign div_word = pub;
    assign n_ratio  = {pub[2*DATA_W +: N_W-DATA_W], pub[DATA_W +: DATA_W]};
    assign r_ratio  = pub[R_W-1:0];

    assign clk_src_vco  = fields.clk_src_vco;
    assign slow_slew    = fields.slow_slew;
    assign xclk_buf_en  = fields.xclk_buf_en;
    assign rclk_buf_en  = fields.rclk_buf_en;
    assign ifbuf_en     = fields.ifbuf_en;
    assign vco_en       = fields.vco_en;
    assign pll_en       = fields.pll_en;
    assign rfamp_en     = fields.rfamp_en;
    assign mixer_en     = fields.mixer_en;
    assign ifchain_en   = fields.ifchain_en;
    assign agc_en       = fields.agc_en;
    assign rx_master_en = fields.rx_master_en;
    assign rx_force_on  = fields.rx_force_on;
    assign cp_code      = fields.cp_code;
    assign lf_code      = fields.lf_code;
    assign cp_steps     = {1'b0, fields.cp_code} + 3'd1;

    AST_STEPS_RANGE: assert property (@(posedge sclk) disable iff (!rst_n)
        (cp_steps >= 3'd1) && (cp_steps <= 3'd4)); // R7

endmodule

// File: tb/spi_cfg_bank_bench.sv
module spi_cfg_bank_bench;

    localparam int CLK_PERIOD = 20;
    localparam int NVEC = 27;

    // {address byte, data byte, expected read byte}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h40, 8'h00, 8'h00}, {8'h41, 8'h00, 8'h60}, {8'h42, 8'h00, 8'h01},
        {8'h43, 8'h00, 8'h0A}, {8'h50, 8'h00, 8'h00}, {8'h51, 8'h00, 8'hBF},
        {8'h52, 8'h00, 8'h1B}, {8'h60, 8'h00, 8'h00}, {8'h33, 8'h00, 8'h00},
        {8'hC0, 8'hFF, 8'h00}, {8'h40, 8'h00, 8'h0F},
        {8'hC1, 8'h13, 8'h00}, {8'h41, 8'h00, 8'h13},
        {8'hC2, 8'hC5, 8'h00}, {8'h42, 8'h00, 8'h05},
        {8'hD0, 8'hFF, 8'h00}, {8'h50, 8'h00, 8'h02},
        {8'hD1, 8'hFF, 8'h00}, {8'h51, 8'h00, 8'hBF},
        {8'hD2, 8'hFF, 8'h00}, {8'h52, 8'h00, 8'h1F},
        {8'hE0, 8'hFF, 8'h00}, {8'h60, 8'h00, 8'h01},
        {8'hC3, 8'hF5, 8'h00}, {8'h43, 8'h00, 8'h05},
        {8'hF3, 8'hAA, 8'h00}, {8'h73, 8'h00, 8'h00}
    };

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [23:0] div_word;
    logic [11:0] n_ratio;
    logic [5:0]  r_ratio;
    logic        clk_src_vco, slow_slew, xclk_buf_en, rclk_buf_en, ifbuf_en;
    logic        vco_en, pll_en, rfamp_en, mixer_en, ifchain_en, agc_en;
    logic        rx_master_en, rx_force_on;
    logic [1:0]  cp_code;
    logic [2:0]  cp_steps;
    logic [2:0]  lf_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) sclk = ~sclk;

    spi_cfg_bank u_spi_cfg_bank (
        .sclk(sclk), .rst_n(rst_n), .strap_mode(strap_mode), .cs_n(cs_n),
        .sdi(sdi), .sdo(sdo), .div_word(div_word), .n_ratio(n_ratio),
        .r_ratio(r_ratio), .clk_src_vco(clk_src_vco), .slow_slew(slow_slew),
        .xclk_buf_en(xclk_buf_en), .rclk_buf_en(rclk_buf_en),
        .ifbuf_en(ifbuf_en), .vco_en(vco_en), .pll_en(pll_en),
        .rfamp_en(rfamp_en), .mixer_en(mixer_en), .ifchain_en(ifchain_en),
        .agc_en(agc_en), .rx_master_en(rx_master_en),
        .rx_force_on(rx_force_on), .cp_code(cp_code), .cp_steps(cp_steps),
        .lf_code(lf_code)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive nbits of a frame, then release the select; collect read bits
    task automatic xfer(input logic [7:0] addr, input logic [7:0] data,
                        input int nbits, output logic [7:0] rd);
        rd = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk); #2;
            if (i == 0) cs_n = 1'b0;
            sdi = (i < 8) ? addr[7-i] : data[15-i];
            if (i >= 8) rd[15-i] = sdo;
        end
        @(negedge sclk); #2;
        cs_n = 1'b1;
        sdi  = 1'b0;
        @(negedge sclk); #2;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge sclk); #2;
        strap_mode = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge sclk);
        #2 rst_n = 1'b1;
        @(negedge sclk); #2;
    endtask

    task automatic fields_check(input logic [3:0] clk, input logic ifb,
                                input logic [7:0] en, input logic [4:0] trim,
                                input logic rfe, input string tag);
        check({rclk_buf_en, xclk_buf_en, slow_slew, clk_src_vco} == clk, tag,
              {rclk_buf_en, xclk_buf_en, slow_slew, clk_src_vco}, clk);
        check(ifbuf_en == ifb, tag, ifbuf_en, ifb);
        check({rx_master_en, 1'b0, agc_en, ifchain_en, mixer_en, rfamp_en,
               pll_en, vco_en} == en, tag,
              {rx_master_en, 1'b0, agc_en, ifchain_en, mixer_en, rfamp_en,
               pll_en, vco_en}, en);
        check({lf_code, cp_code} == trim, tag, {lf_code, cp_code}, trim);
        check(rx_force_on == rfe, tag, rx_force_on, rfe);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        do_reset(1'b0);

        // R4 R5 R6 R7 R10: reset state with strap 0
        check(div_word == 24'h006001, "R4 div_word strap0", div_word, 24'h006001);
        check(n_ratio == 12'd96, "R4 n_ratio strap0", n_ratio, 96);
        check(r_ratio == 6'd1, "R4 r_ratio strap0", r_ratio, 1);
        fields_check(4'b1010, 1'b0, 8'hBF, 5'b11011, 1'b0, "R6 fields strap0");
        check(cp_steps == 3'd4, "R7 steps code 11", cp_steps, 4);
        check(sdo == 1'b0, "R2 sdo idle", sdo, 0);

        // R1 R2 R3 R5 R9 R11: table of frames
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][23:16], VEC[v][15:8], 16, rd);
            if (!VEC[v][23])
                check(rd == VEC[v][7:0], $sformatf("R1 R2 read idx %0h", VEC[v][22:16]),
                      rd, VEC[v][7:0]);
            check(sdo == 1'b0, "R2 sdo low after frame", sdo, 0);
        end

        // R3 R6: published word and fields after the table
        check(div_word == 24'h0F1305, "R3 publish after 0x42", div_word, 24'h0F1305);
        check(n_ratio == 12'hF13, "R3 n_ratio", n_ratio, 12'hF13);
        check(r_ratio == 6'd5, "R3 r_ratio", r_ratio, 5);
        fields_check(4'b0101, 1'b1, 8'hBF, 5'b11111, 1'b1, "R6 fields written");

        // R3: staging without commit
        xfer(8'hC0, 8'h06, 16, rd);
        xfer(8'hC1, 8'h13, 16, rd);
        check(div_word == 24'h0F1305, "R3 staged not published", div_word, 24'h0F1305);
        xfer(8'h40, 8'h00, 16, rd);
        check(rd == 8'h06, "R3 staged readback", rd, 8'h06);
        check(div_word == 24'h0F1305, "R11 read leaves word", div_word, 24'h0F1305);
        xfer(8'hC2, 8'h13, 16, rd);
        check(div_word == 24'h061313, "R3 commit all", div_word, 24'h061313);
        check(n_ratio == 12'd1555, "R3 n after commit", n_ratio, 1555);
        check(r_ratio == 6'd19, "R3 r after commit", r_ratio, 19);

        // R7: charge-pump steps for each code
        for (int c = 0; c < 4; c++) begin
            xfer(8'hD2, 8'(c), 16, rd);
            check(cp_steps == 3'(c + 1), "R7 cp_steps", cp_steps, c + 1);
        end

        // R8: aborted frames
        xfer(8'hC2, 8'h3F, 12, rd);
        check(div_word == 24'h061313, "R8 abort in data phase", div_word, 24'h061313);
        xfer(8'h42, 8'h00, 16, rd);
        check(rd == 8'h13, "R8 abort left 0x42", rd, 8'h13);
        xfer(8'hE0, 8'h00, 5, rd);
        check(rx_force_on == 1'b1, "R8 abort in address phase", rx_force_on, 1);

        // R9: unmapped write leaves outputs
        xfer(8'hFF, 8'h00, 16, rd);
        check(div_word == 24'h061313, "R9 unmapped write", div_word, 24'h061313);
        check(rx_force_on == 1'b1, "R9 unmapped write field", rx_force_on, 1);

        // R10: strap change outside reset has no effect
        strap_mode = 1'b1;
        repeat (4) @(negedge sclk);
        #2;
        check(div_word == 24'h061313 && xclk_buf_en == 1'b1 && clk_src_vco == 1'b1,
              "R10 strap ignored", {div_word, xclk_buf_en, clk_src_vco},
              {24'h061313, 2'b11});

        // R4 R10: reload with strap 1
        xfer(8'hC0, 8'h00, 16, rd);
        do_reset(1'b1);
        check(div_word == 24'h061313, "R4 div_word strap1", div_word, 24'h061313);
        check(n_ratio == 12'd1555, "R4 n_ratio strap1", n_ratio, 1555);
        check(r_ratio == 6'd19, "R4 r_ratio strap1", r_ratio, 19);
        fields_check(4'b1111, 1'b0, 8'hBF, 5'b11011, 1'b0, "R10 fields strap1");
        xfer(8'h43, 8'h00, 16, rd);
        check(rd == 8'h0F, "R4 read 0x43 strap1", rd, 8'h0F);
        xfer(8'h40, 8'h00, 16, rd);
        check(rd == 8'h06, "R10 staged reloaded", rd, 8'h06);

        // R10: strap back to 0 without reset keeps strap-1 values
        strap_mode = 1'b0;
        repeat (3) @(negedge sclk);
        #2;
        check(div_word == 24'h061313, "R10 strap release ignored", div_word, 24'h061313);

        // R10: reload with strap 0 again
        do_reset(1'b0);
        check(div_word == 24'h006001, "R10 reload strap0", div_word, 24'h006001);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule